// File: doc/BRIEF.md
# Stream-Register Snoop Filter with Wrap Reclamation

This block decides, for each incoming snoop, whether the local cache can possibly hold the requested line. It keeps a few stream registers. Each register has a reference line address and a care mask. A line is covered by a register when the line agrees with the reference on every bit whose mask bit is set. Bits whose mask bit is clear are ignored. When the cache allocates a line, the line is folded into one register. The mask bits where the new line disagrees with that register's reference are cleared. Over time the covered set can only grow, so the filter never drops a snoop for a line that is really cached.

Growth makes the registers coarse. To recover precision, the block counts replacements in every cache set. The cache replaces round-robin within a set. Once every set has seen more replacements than it has ways, every line present before that point has been evicted. At that moment the active registers are moved into a shadow bank and the active bank starts empty. Lookups consult both banks. At the following wrap the old shadow contents are discarded and replaced by the active ones.

Top module: `stream_snoop_filter`

## Requirements
- R1: After reset every register in both banks is empty, and every valid snoop is dropped (`snoop_drop`=1, `snoop_hit`=0).
- R2: A line is covered by a valid register when it equals the reference on all bit positions where the mask is 1; positions with mask 0 are ignored.
- R3: An allocation placed into an empty register sets its reference to the allocated line and its mask to all ones, so only that exact line is covered.
- R4: While any active register is empty, an allocation goes into the lowest-indexed empty register and no filled register changes.
- R5: When all active registers are filled, an allocation merges into the register whose reference shares the longest run of equal bits counted down from the most significant bit. That register's mask loses every bit where the line differs from the reference, and its reference is unchanged.
- R6: A wrap is declared only when every set has recorded at least WAYS+1 replacements since reset or the last wrap. A set that is one short prevents it.
- R7: In the cycle after a wrap is declared, the shadow bank holds the former active contents and the active bank is empty. Lines covered by either bank still hit.
- R8: At each later wrap, the previous shadow contents are discarded and no longer cause hits.
- R9: All per-set replacement counts restart from zero when a wrap is declared.
- R10: `snoop_hit` and `snoop_drop` are combinational in the current register state. Both are 0 when `snoop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A line is being allocated into the cache |
| alloc_line | input | LINE_W (12) | Line address being allocated |
| repl_valid | input | 1 | A replacement happened in one set |
| repl_set | input | $clog2(NSETS) (3) | Set index of that replacement |
| snoop_valid | input | 1 | A snoop query is presented |
| snoop_line | input | LINE_W (12) | Line address being snooped |
| snoop_hit | output | 1 | Line may be cached; the snoop must be performed |
| snoop_drop | output | 1 | Line is certainly absent; the snoop can be skipped |

## Verification
The checks rely on a few properties of the inputs. Replacement events must name a set inside the configured range. A replacement count only means "whole cache replaced" when the cache really does use round-robin replacement within each set. The stimulus issues set indices within range. It places each allocation and each replacement burst in its own cycles, so the effect of a wrap on the two banks can be observed alone before the next allocation. Snoops are applied and sampled between clock edges. This matches the combinational query path, and no register update is involved in a query.

// File: rtl/stream_filter_pkg.sv
package stream_filter_pkg;

    localparam int LINE_W = 12;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic  valid;
        line_t ref_line;
        line_t care;
    } sreg_t;

    function automatic logic covers(sreg_t r, line_t a);
        return r.valid && (((a ^ r.ref_line) & r.care) == '0);
    endfunction

    // Number of equal bits counted from the top until the first difference.
    function automatic int prefix_len(line_t a, line_t b);
        int   n;
        logic stop;
        n    = 0;
        stop = 1'b0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            if (!stop && (a[i] == b[i])) n++;
            else stop = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/stream_match.sv
module stream_match
    import stream_filter_pkg::*;
#(
    parameter int NREG = 4
) (
    input  sreg_t [NREG-1:0] regs_i,
    input  line_t            line_i,
    output logic             hit_o
);
    logic [NREG-1:0] per_reg;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign per_reg[g] = covers(regs_i[g], line_i);
    end

    assign hit_o = |per_reg;
endmodule

// File: rtl/wrap_detector.sv
module wrap_detector #(
    parameter int NSETS = 8,
    parameter int NWAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     repl_valid,
    input  logic [$clog2(NSETS)-1:0] repl_set,
    output logic                     wrap_o
);
    localparam int CW = $clog2(NWAYS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(NWAYS);

    logic [CW-1:0] cnt [NSETS];
    logic [NSETS-1:0] over;

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        assign over[s] = (cnt[s] > LIMIT);

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[s] <= '0;
            end else begin
                // Counts saturate at WAYS+1 and restart on a wrap; an event
                // arriving in the wrap cycle is counted from zero.
                if (repl_valid && (repl_set == s[$clog2(NSETS)-1:0]))
                    cnt[s] <= wrap_o ? CW'(1) : (over[s] ? cnt[s] : cnt[s] + CW'(1));
                else if (wrap_o)
                    cnt[s] <= '0;
            end
        end

        AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
            wrap_o |=> cnt[s] <= CW'(1)); // R9
    end

    assign wrap_o = &over;
endmodule

// File: rtl/stream_bank.sv
module stream_bank
    import stream_filter_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             alloc_valid,
    input  line_t            alloc_line,
    output sreg_t [NREG-1:0] regs_o
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    sreg_t [NREG-1:0] regs, start, nxt;
    logic [IDX_W-1:0] pick;

    always_comb begin
        start = clear_i ? '0 : regs;
    end

    // Lowest empty register first; otherwise longest top-bit agreement,
    // ties going to the lowest index.
    always_comb begin
        logic found;
        int   best;
        found = 1'b0;
        best  = -1;
        pick  = '0;
        for (int i = 0; i < NREG; i++) begin
            if (!found && !start[i].valid) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NREG; i++) begin
                if (prefix_len(start[i].ref_line, alloc_line) > best) begin
                    best = prefix_len(start[i].ref_line, alloc_line);
                    pick = IDX_W'(i);
                end
            end
        end
    end

    always_comb begin
        nxt = start;
        if (alloc_valid) begin
            if (!start[pick].valid) begin
                nxt[pick].valid    = 1'b1;
                nxt[pick].ref_line = alloc_line;
                nxt[pick].care     = '1;
            end else begin
                nxt[pick].care = start[pick].care & ~(start[pick].ref_line ^ alloc_line);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= '0;
        else     regs <= nxt;
    end

    assign regs_o = regs;

    function automatic logic any_cover(sreg_t [NREG-1:0] r, line_t a);
        logic h;
        h = 1'b0;
        for (int i = 0; i < NREG; i++) h = h | covers(r[i], a);
        return h;
    endfunction

    function automatic int filled(sreg_t [NREG-1:0] r);
        int n;
        n = 0;
        for (int i = 0; i < NREG; i++) n += int'(r[i].valid);
        return n;
    endfunction

    AST_ALLOC_COVERED: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> any_cover(regs, $past(alloc_line))); // R3

    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> filled(regs) >= filled($past(regs))); // R4

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (rst)
            (!clear_i && regs[g].valid) |=>
                ((regs[g].care & ~$past(regs[g].care)) == '0)); // R5
    end
endmodule

// File: rtl/stream_snoop_filter.sv
module stream_snoop_filter
    import stream_filter_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int NSETS = 8,
    parameter int NWAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_valid,
    input  logic [LINE_W-1:0]        alloc_line,
    input  logic                     repl_valid,
    input  logic [$clog2(NSETS)-1:0] repl_set,
    input  logic                     snoop_valid,
    input  logic [LINE_W-1:0]        snoop_line,
    output logic                     snoop_hit,
    output logic                     snoop_drop
);
    sreg_t [NREG-1:0] active, shadow;
    logic wrap, hit_act, hit_shd;

    wrap_detector #(.NSETS(NSETS), .NWAYS(NWAYS)) u_wrap (
        .clk(clk), .rst(rst),
        .repl_valid(repl_valid), .repl_set(repl_set),
        .wrap_o(wrap)
    );

    stream_bank #(.NREG(NREG)) u_active (
        .clk(clk), .rst(rst), .clear_i(wrap),
        .alloc_valid(alloc_valid), .alloc_line(alloc_line),
        .regs_o(active)
    );

    always_ff @(posedge clk) begin
        if (rst)       shadow <= '0;
        else if (wrap) shadow <= active;
    end

    stream_match #(.NREG(NREG)) u_match_act (
        .regs_i(active), .line_i(snoop_line), .hit_o(hit_act));
    stream_match #(.NREG(NREG)) u_match_shd (
        .regs_i(shadow), .line_i(snoop_line), .hit_o(hit_shd));

    assign snoop_hit  = snoop_valid &  (hit_act | hit_shd);
    assign snoop_drop = snoop_valid & ~(hit_act | hit_shd);

    function automatic logic none_valid(sreg_t [NREG-1:0] r);
        logic v;
        v = 1'b0;
        for (int i = 0; i < NREG; i++) v = v | r[i].valid;
        return !v;
    endfunction

    AST_SHADOW_TAKES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        wrap |=> shadow == $past(active)); // R7

    AST_ACTIVE_EMPTIED: assert property (@(posedge clk) disable iff (rst)
        (wrap && !alloc_valid) |=> none_valid(active)); // R7

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow)); // R8

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snoop_hit, snoop_drop})); // R10
endmodule

// File: tb/stream_snoop_filter_test.sv
module stream_snoop_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;
    localparam int NS = 8;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 1'b0;
    logic [LW-1:0] alloc_line = '0;
    logic repl_valid = 1'b0;
    logic [2:0] repl_set = '0;
    logic snoop_valid = 1'b0;
    logic [LW-1:0] snoop_line = '0;
    logic snoop_hit, snoop_drop;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_snoop_filter uut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_line(alloc_line),
        .repl_valid(repl_valid), .repl_set(repl_set),
        .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .snoop_hit(snoop_hit), .snoop_drop(snoop_drop)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Query between edges; the answer is combinational.
    task automatic probe(input logic [LW-1:0] a, input logic exp_hit, input string tag);
        snoop_valid = 1'b1;
        snoop_line  = a;
        #1;
        check(snoop_hit, exp_hit, tag);
        check(snoop_drop, !exp_hit, tag);
        snoop_valid = 1'b0;
    endtask

    task automatic do_alloc(input logic [LW-1:0] a);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_line  = a;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_repl(input int set, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            repl_valid = 1'b1;
            repl_set   = set[2:0];
        end
        @(negedge clk);
        repl_valid = 1'b0;
    endtask

    task automatic t_reset;
        probe(12'h000, 1'b0, "R1 empty after reset");
        probe(12'hABC, 1'b0, "R1 empty after reset");
    endtask

    task automatic t_fill;
        do_alloc(12'h100);
        do_alloc(12'h200);
        do_alloc(12'h300);
        do_alloc(12'h400);
        probe(12'h100, 1'b1, "R3 exact line covered");
        probe(12'h101, 1'b0, "R3 neighbour not covered");
        probe(12'h200, 1'b1, "R4 second register kept");
        probe(12'h400, 1'b1, "R4 fourth register filled");
    endtask

    task automatic t_merge;
        do_alloc(12'h101);           // closest to 0x100, clears bit 0
        probe(12'h101, 1'b1, "R5 merged line");
        probe(12'h103, 1'b0, "R5 bit 1 still cared");
        probe(12'h200, 1'b1, "R5 other register untouched");
        do_alloc(12'h102);           // clears bit 1 of same register
        probe(12'h103, 1'b1, "R2 ignored bits match anything");
        probe(12'h104, 1'b0, "R2 cared bit mismatches");
    endtask

    task automatic t_first_wrap;
        for (int s = 0; s < NS - 1; s++) do_repl(s, NW + 1);
        do_repl(NS - 1, NW);         // one short: no wrap yet
        do_alloc(12'h580);           // merges with 0x400 only if no wrap
        probe(12'h480, 1'b1, "R6 no wrap with one set short");
        probe(12'h481, 1'b0, "R2 low bit still cared");
        do_repl(NS - 1, 1);          // completes the wrap
        @(negedge clk);
        do_alloc(12'h105);           // goes into empty active bank
        probe(12'h105, 1'b1, "R7 new active entry");
        probe(12'h106, 1'b0, "R7 active restarted exact");
        probe(12'h480, 1'b1, "R7 shadow still consulted");
        probe(12'h103, 1'b1, "R7 shadow still consulted");
    endtask

    task automatic t_second_wrap;
        for (int s = 0; s < NS; s++) do_repl(s, NW);
        probe(12'h480, 1'b1, "R9 counts restarted after wrap");
        for (int s = 0; s < NS; s++) do_repl(s, 1);
        @(negedge clk);
        probe(12'h480, 1'b0, "R8 old shadow discarded");
        probe(12'h103, 1'b0, "R8 old shadow discarded");
        probe(12'h105, 1'b1, "R8 previous active now shadow");
    endtask

    task automatic t_idle;
        snoop_valid = 1'b0;
        snoop_line  = 12'h105;
        #1;
        check(snoop_hit, 1'b0, "R10 no hit without valid");
        check(snoop_drop, 1'b0, "R10 no drop without valid");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_merge();
        t_first_wrap();
        t_second_wrap();
        t_idle();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule